// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block turns one load-multiple or store-multiple request into a stream of word accesses for a 32-bit bus addressed in bytes. A request gives a base address, a 16-bit mask that selects registers, a two-bit addressing mode and a writeback flag. The block then issues one access for each selected register. Each access carries a byte address and the index of its register, and moves through a valid/ready handshake toward a memory port.

Whatever the mode, the sequencer visits registers from the lowest index to the highest, and each address is 4 bytes above the one before it. The mode only moves the starting address below or above the base, and picks whether the updated base grows or shrinks. When the last access is accepted, the block pulses done. If writeback was requested, it also presents the new base value with an enable pulse.

Top module: `blkxfer_seq`

## Requirements
- R1: The number of accesses issued for a request equals the number of set bits in the register mask, exactly one per set bit.
- R2: Accesses go out in ascending register index order. Each access address is 4 greater than the previous access of the same request, in every mode.
- R3: Mode encoding: 00 increment-after, 01 increment-before, 10 decrement-after, 11 decrement-before. In mode 00 the first address is the base. In mode 01 the first address is the base plus 4.
- R4: In mode 10 the first address is the base minus 4×count plus 4, and the final address equals the base.
- R5: In mode 11 the first address is the base minus 4×count, and the final address is the base minus 4.
- R6: When the writeback flag was set with the request, `wb_valid_o` pulses together with `done_o`, and `wb_value_o` holds the base plus 4×count for modes 00 and 01, or the base minus 4×count for modes 10 and 11. When the flag was clear, `wb_valid_o` stays low.
- R7: The address of the final access equals the end address computed from the base, the mode and the count.
- R8: An all-zero mask issues no access. `done_o` rises on the second clock edge after the edge that samples the start, and `wb_valid_o` stays low.
- R9: While `acc_valid_o` is high and `acc_ready_i` is low, the address and register index hold. At most one access completes per clock.
- R10: `busy_o` is high from the edge that accepts a start until the edge that raises `done_o`. A start seen while busy is ignored and does not disturb the running sequence.
- R11: After a synchronous reset, `acc_valid_o`, `busy_o`, `done_o` and `wb_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe, accepted when idle |
| base_i | input | 32 | Base address register value |
| mask_i | input | 16 | Register-select mask, bit n selects register n |
| mode_i | input | 2 | Addressing mode (see R3) |
| wb_en_i | input | 1 | Request writeback of the updated base |
| acc_valid_o | output | 1 | Access is presented |
| acc_ready_i | input | 1 | Memory port accepts the access |
| acc_addr_o | output | 32 | Byte address of the access |
| acc_reg_o | output | 4 | Register index of the access |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse at the end of a sequence |
| wb_valid_o | output | 1 | Writeback enable pulse |
| wb_value_o | output | 32 | Updated base value |

## Verification
The embedded assertions check, on every cycle, that a stalled access holds its address and index, that consecutive accepted accesses step by 4 with rising register index, and that the final access lands on the computed end address. They also check that the access count at done matches the mask population, that writeback never pulses without done, and that busy only falls with done. What only the bench scenarios can show is absolute correctness against the requirements: the start address and writeback value for each mode, the exact latency of an empty request, and that a start poked during a running sequence leaves it unchanged. For these, the bench compares every handshake with values it computes from the base, mask and mode under random stalls.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;
  typedef enum logic [1:0] {
    MODE_INC_AFTER  = 2'b00,
    MODE_INC_BEFORE = 2'b01,
    MODE_DEC_AFTER  = 2'b10,
    MODE_DEC_BEFORE = 2'b11
  } xfer_mode_e;
endpackage

// File: rtl/blkxfer_popcnt.sv
module blkxfer_popcnt #(
  parameter int N     = 16,
  parameter int CNT_W = $clog2(N + 1)
) (
  input  logic [N-1:0]     mask_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < N; i++) begin
      cnt_o = cnt_o + CNT_W'(mask_i[i]);
    end
  end
endmodule

// File: rtl/blkxfer_lowpick.sv
module blkxfer_lowpick #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     mask_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [N-1:0]     rest_o
);
  // lowest set bit wins; scanning downward lets the last hit be the lowest
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask_i[i]) idx_o = IDX_W'(i);
    end
    rest_o = mask_i & (mask_i - N'(1));
  end
endmodule

// File: rtl/blkxfer_addrcalc.sv
module blkxfer_addrcalc
  import blkxfer_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 5,
  parameter int WORD_SHIFT = 2
) (
  input  logic [ADDR_W-1:0] base_i,
  input  xfer_mode_e        mode_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [ADDR_W-1:0] first_o,
  output logic [ADDR_W-1:0] last_o,
  output logic [ADDR_W-1:0] wb_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << WORD_SHIFT;

  logic [ADDR_W-1:0] span;

  always_comb begin
    span = ADDR_W'(cnt_i) << WORD_SHIFT;
    unique case (mode_i)
      MODE_INC_AFTER:  first_o = base_i;
      MODE_INC_BEFORE: first_o = base_i + STEP;
      MODE_DEC_AFTER:  first_o = base_i - span + STEP;
      default:         first_o = base_i - span;
    endcase
    if (mode_i == MODE_INC_AFTER || mode_i == MODE_INC_BEFORE) wb_o = base_i + span;
    else                                                        wb_o = base_i - span;
    last_o = first_o + span - STEP;
  end
endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
  import blkxfer_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int REG_N      = 16,
  parameter int WORD_SHIFT = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start_i,
  input  logic [ADDR_W-1:0]        base_i,
  input  logic [REG_N-1:0]         mask_i,
  input  logic [1:0]               mode_i,
  input  logic                     wb_en_i,
  output logic                     acc_valid_o,
  input  logic                     acc_ready_i,
  output logic [ADDR_W-1:0]        acc_addr_o,
  output logic [$clog2(REG_N)-1:0] acc_reg_o,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     wb_valid_o,
  output logic [ADDR_W-1:0]        wb_value_o
);
  localparam int IDX_W = $clog2(REG_N);
  localparam int CNT_W = $clog2(REG_N + 1);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << WORD_SHIFT;

  logic [CNT_W-1:0]  sel_cnt;
  logic [ADDR_W-1:0] calc_first, calc_last, calc_wb;
  logic [IDX_W-1:0]  new_idx, rem_idx;
  logic [REG_N-1:0]  new_rest, rem_rest;

  logic              busy_q, valid_q, empty_q, done_q, wbv_q, wbflag_q;
  logic [REG_N-1:0]  rem_q;
  logic [ADDR_W-1:0] addr_q, end_q, wbpend_q, wbout_q;
  logic [IDX_W-1:0]  idx_q;
  logic [CNT_W-1:0]  issued_q, expect_q;

  blkxfer_popcnt #(.N(REG_N), .CNT_W(CNT_W)) u_cnt (
    .mask_i(mask_i), .cnt_o(sel_cnt)
  );

  blkxfer_addrcalc #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .WORD_SHIFT(WORD_SHIFT)) u_calc (
    .base_i(base_i), .mode_i(xfer_mode_e'(mode_i)), .cnt_i(sel_cnt),
    .first_o(calc_first), .last_o(calc_last), .wb_o(calc_wb)
  );

  blkxfer_lowpick #(.N(REG_N), .IDX_W(IDX_W)) u_pick_new (
    .mask_i(mask_i), .idx_o(new_idx), .rest_o(new_rest)
  );

  blkxfer_lowpick #(.N(REG_N), .IDX_W(IDX_W)) u_pick_rem (
    .mask_i(rem_q), .idx_o(rem_idx), .rest_o(rem_rest)
  );

  logic accept, fire, final_beat;
  assign accept     = start_i && !busy_q;
  assign fire       = valid_q && acc_ready_i;
  assign final_beat = fire && (rem_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      valid_q  <= 1'b0;
      empty_q  <= 1'b0;
      done_q   <= 1'b0;
      wbv_q    <= 1'b0;
      wbflag_q <= 1'b0;
      rem_q    <= '0;
      addr_q   <= '0;
      end_q    <= '0;
      wbpend_q <= '0;
      wbout_q  <= '0;
      idx_q    <= '0;
      issued_q <= '0;
      expect_q <= '0;
    end else begin
      done_q <= 1'b0;
      wbv_q  <= 1'b0;
      if (accept) begin
        busy_q   <= 1'b1;
        valid_q  <= (sel_cnt != '0);
        empty_q  <= (sel_cnt == '0);
        addr_q   <= calc_first;
        end_q    <= calc_last;
        idx_q    <= new_idx;
        rem_q    <= new_rest;
        wbpend_q <= calc_wb;
        wbflag_q <= wb_en_i;
        issued_q <= '0;
        expect_q <= sel_cnt;
      end else if (empty_q) begin
        empty_q <= 1'b0;
        busy_q  <= 1'b0;
        done_q  <= 1'b1;
      end else if (fire) begin
        issued_q <= issued_q + CNT_W'(1);
        if (rem_q == '0) begin
          valid_q <= 1'b0;
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          wbv_q   <= wbflag_q;
          if (wbflag_q) wbout_q <= wbpend_q;
        end else begin
          addr_q <= addr_q + STEP;
          idx_q  <= rem_idx;
          rem_q  <= rem_rest;
        end
      end
    end
  end

  assign acc_valid_o = valid_q;
  assign acc_addr_o  = addr_q;
  assign acc_reg_o   = idx_q;
  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign wb_valid_o  = wbv_q;
  assign wb_value_o  = wbout_q;

  // R9: stalled access keeps address and index
  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    acc_valid_o && !acc_ready_i |=> acc_valid_o && $stable(acc_addr_o) && $stable(acc_reg_o));

  // R2: accepted non-final beat advances by one word and to a higher index
  a_r2_ascending_step: assert property (@(posedge clk) disable iff (rst)
    fire && (rem_q != '0) |=> acc_valid_o && (acc_addr_o == $past(acc_addr_o) + STEP)
                              && (acc_reg_o > $past(acc_reg_o)));

  // R7: final beat lands on the end address latched at start
  a_r7_last_is_end: assert property (@(posedge clk) disable iff (rst)
    final_beat |-> acc_addr_o == end_q);

  // R1: beats completed equal the mask population when done pulses
  a_r1_beat_count: assert property (@(posedge clk) disable iff (rst)
    done_o |-> issued_q == expect_q);

  // R6: writeback enable only with done
  a_r6_wb_with_done: assert property (@(posedge clk) disable iff (rst)
    wb_valid_o |-> done_o);

  // R10: busy only drops together with done
  a_r10_busy_until_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);

  // R8: empty mask gives no access and done two edges after acceptance
  a_r8_empty_mask: assert property (@(posedge clk) disable iff (rst)
    accept && (mask_i == '0) |=> !acc_valid_o ##1 (done_o && !wb_valid_o && !acc_valid_o));
endmodule

// File: tb/blkxfer_seq_tb_top.sv
module blkxfer_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] base_i = '0;
  logic [15:0] mask_i = '0;
  logic [1:0]  mode_i = '0;
  logic        wb_en_i = 1'b0;
  logic        acc_ready_i = 1'b0;
  logic        acc_valid_o, busy_o, done_o, wb_valid_o;
  logic [31:0] acc_addr_o, wb_value_o;
  logic [3:0]  acc_reg_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  blkxfer_seq dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .base_i(base_i), .mask_i(mask_i),
    .mode_i(mode_i), .wb_en_i(wb_en_i), .acc_valid_o(acc_valid_o),
    .acc_ready_i(acc_ready_i), .acc_addr_o(acc_addr_o), .acc_reg_o(acc_reg_o),
    .busy_o(busy_o), .done_o(done_o), .wb_valid_o(wb_valid_o), .wb_value_o(wb_value_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int popc(input logic [15:0] m);
    int n = 0;
    for (int i = 0; i < 16; i++) n += int'(m[i]);
    return n;
  endfunction

  function automatic logic [31:0] exp_first(input logic [31:0] b, input logic [1:0] md, input int n);
    case (md)
      2'b00:   return b;
      2'b01:   return b + 32'd4;
      2'b10:   return b - 32'(4 * n) + 32'd4;
      default: return b - 32'(4 * n);
    endcase
  endfunction

  function automatic logic [31:0] exp_wb(input logic [31:0] b, input logic [1:0] md, input int n);
    return md[1] ? b - 32'(4 * n) : b + 32'(4 * n);
  endfunction

  task automatic run_op(input logic [31:0] b, input logic [15:0] m, input logic [1:0] md,
                        input bit wb, input int stall_pct, input bit poke);
    int n = popc(m);
    logic [31:0] first = exp_first(b, md, n);
    int k = 0;
    int scan = 0;
    int cyc = 0;
    bit got_done = 0;
    bit prev_stall = 0;
    @(negedge clk);
    base_i = b; mask_i = m; mode_i = md; wb_en_i = wb; start_i = 1'b1; acc_ready_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R10 busy after start", 32'(busy_o), 32'd1);
    if (n == 0) begin
      chk(!acc_valid_o && !done_o, "R8 empty no access yet", {acc_valid_o, done_o}, 32'd0);
      @(negedge clk);
      chk(done_o == 1'b1, "R8 empty done latency", 32'(done_o), 32'd1);
      chk(!wb_valid_o && !acc_valid_o, "R8 empty no writeback", {acc_valid_o, wb_valid_o}, 32'd0);
      chk(!busy_o, "R10 idle at done", 32'(busy_o), 32'd0);
      return;
    end
    while (!got_done && cyc < 400) begin
      if (done_o) begin
        got_done = 1;
        chk(k == n, "R1 access count", 32'(k), 32'(n));
        chk(wb_valid_o == wb, "R6 writeback enable", 32'(wb_valid_o), 32'(wb));
        if (wb) chk(wb_value_o == exp_wb(b, md, n), "R6 writeback value", wb_value_o, exp_wb(b, md, n));
        chk(!busy_o, "R10 busy low at done", 32'(busy_o), 32'd0);
      end else begin
        bit rdy;
        if (acc_valid_o) begin
          int eidx = scan;
          logic [31:0] ea;
          while (eidx < 16 && !m[eidx]) eidx++;
          ea = first + 32'(4 * k);
          if (k >= n) chk(1'b0, "R1 extra access", 32'(k), 32'(n));
          else begin
            if (prev_stall) chk(acc_addr_o == ea, "R9 hold addr", acc_addr_o, ea);
            else if (k == 0) chk(acc_addr_o == ea, md[1] ? (md[0] ? "R5 first addr" : "R4 first addr")
                                                        : "R3 first addr", acc_addr_o, ea);
            else if (k == n - 1) chk(acc_addr_o == ea, "R7 last addr", acc_addr_o, ea);
            else chk(acc_addr_o == ea, "R2 addr step", acc_addr_o, ea);
            chk(acc_reg_o == 4'(eidx), "R2 register order", 32'(acc_reg_o), 32'(eidx));
            if (k == n - 1 && md == 2'b10) chk(acc_addr_o == b, "R4 last equals base", acc_addr_o, b);
            if (k == n - 1 && md == 2'b11) chk(acc_addr_o == b - 32'd4, "R5 last base minus 4", acc_addr_o, b - 32'd4);
          end
          rdy = ($urandom_range(99) >= stall_pct);
          if (rdy) begin k++; scan = eidx + 1; end
          prev_stall = !rdy;
          if (poke && k == 1) begin
            start_i = 1'b1; base_i = 32'hDEAD0000; mask_i = 16'hFFFF; mode_i = 2'b00;
          end
        end else begin
          rdy = 1'b0;
          chk(1'b0, "R10 busy without access", 32'(acc_valid_o), 32'd1);
        end
        acc_ready_i = rdy;
      end
      @(negedge clk);
      start_i = 1'b0;
      cyc++;
    end
    if (!got_done) chk(1'b0, "R1 sequence never finished", 32'(k), 32'(n));
    acc_ready_i = 1'b0;
    chk(!done_o && !wb_valid_o && !busy_o, "R10 done is one pulse", {done_o, wb_valid_o, busy_o}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!acc_valid_o && !busy_o && !done_o && !wb_valid_o, "R11 reset state",
        {acc_valid_o, busy_o, done_o, wb_valid_o}, 32'd0);
    // seven registers, decrement after: first at base-24, writeback base-28
    run_op(32'h0000_1000, 16'h00FE, 2'b10, 1'b1, 0, 1'b0);
    run_op(32'h0000_1000, 16'h00FE, 2'b11, 1'b1, 0, 1'b0);
    run_op(32'h2000_0040, 16'h8001, 2'b00, 1'b1, 30, 1'b0);
    run_op(32'h2000_0040, 16'hFFFF, 2'b01, 1'b1, 50, 1'b0);
    run_op(32'h0000_0100, 16'h0000, 2'b10, 1'b1, 0, 1'b0);
    run_op(32'h0000_0100, 16'h0010, 2'b11, 1'b0, 0, 1'b0);
    run_op(32'h0000_0008, 16'hA5A5, 2'b10, 1'b1, 60, 1'b1);
    run_op(32'h0000_0000, 16'h0003, 2'b11, 1'b1, 20, 1'b0);
    for (int t = 0; t < 40; t++) begin
      logic [15:0] m = 16'($urandom());
      if (t % 9 == 0) m = '0;
      run_op({$urandom_range(32'h3FFF_FFFF), 2'b00}, m, 2'($urandom_range(3)),
             1'($urandom_range(1)), $urandom_range(60), 1'($urandom_range(1)));
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule